// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block is the column-burst sequencer of a synchronous DRAM model. A mode-set command loads a 14-bit address/bank word into a mode register. The register holds the burst length, the address ordering, the read latency and the write mode. Each read or write command then starts a burst. The block drives one column address per clock, flags the final beat and, for reads, raises a data-valid strobe a programmed number of cycles after each beat.

A controller model or a memory model places the block beside its data array. The array indexes its columns with `col_addr_out` and presents read data while `rd_data_valid` is high. A new read or write may arrive on any clock. It drops what is left of the running burst and starts a fresh full-length burst.

The sequencer is a two-state machine, `ST_IDLE` and `ST_BURST`.

| Transition | From | To | Condition |
|---|---|---|---|
| START | `ST_IDLE` | `ST_BURST` | A read or write command arrives. |
| ADVANCE | `ST_BURST` | `ST_BURST` | No command arrives and the beat is not the final one; the beat counter steps. |
| FINISH | `ST_BURST` | `ST_IDLE` | No command arrives and the final beat is on the outputs. |
| RESTART | `ST_BURST` | `ST_BURST` | A command arrives during a burst; the counter clears and new parameters are latched. |

Top module: `sdram_burst_colgen`

## Requirements
- R1: `cmd_type` selects the command when `cmd_valid` is 1: 00 is mode-set, 01 is read, 10 is write. In the mode-set word, `addr_in[2:0]` selects burst length (000=1, 001=2, 010=4, 011=8). `addr_in[3]` selects ordering (0 sequential, 1 interleaved). `addr_in[6:4]` selects read latency (010=2, 011=3). `addr_in[9]` set to 1 makes writes single-beat.
- R2: A mode-set word is rejected if it uses a reserved length or latency code, or if any of `addr_in[13:10]` or `addr_in[8:7]` is nonzero. A rejected word sets `mode_error` on the next cycle and leaves the stored mode unchanged. An accepted mode-set clears `mode_error`.
- R3: After reset, the mode is burst length 1, sequential, latency 2 and burst writes. `beat_valid`, `last_beat`, `rd_data_valid` and `mode_error` are all 0.
- R4: The cycle after a read or write command, `beat_valid` rises and `col_addr_out` equals `addr_in[9:0]` of that command. `beat_valid` then stays high for exactly the burst length in consecutive cycles. Length and ordering are those in force when the command was taken.
- R5: In sequential order, the low log2(BL) column bits count up from the start value and wrap within the aligned block.
- R6: In interleaved order, the low log2(BL) bits of beat k equal the start low bits XOR k.
- R7: The column bits above the low log2(BL) bits do not change during a burst.
- R8: `last_beat` is high on the final beat of a burst and on no other cycle.
- R9: With single-beat writes selected, a write produces exactly one beat. Reads still use the full burst length.
- R10: A read or write arriving during a burst restarts the sequence at its own column with a full-length burst. The remaining old addresses are never issued.
- R11: `rd_data_valid` is high exactly CL cycles after each read beat, where CL is the programmed latency. Write beats never raise it.
- R12: A command with `cmd_valid` at 0, or with `cmd_type` 11, changes neither the mode, `mode_error` nor the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_type | input | 2 | Command code (R1) |
| addr_in | input | 14 | Bank bits [13:12] and address bits [11:0] |
| col_addr_out | output | 10 | Column address of the current beat |
| beat_valid | output | 1 | A burst beat is on `col_addr_out` |
| last_beat | output | 1 | Current beat is the last of its burst |
| rd_data_valid | output | 1 | Read data slot, CL cycles after a read beat |
| mode_error | output | 1 | Last mode-set word was rejected |

## Verification
Several properties are checked on every cycle:
- a command's column appears as the next beat;
- a rejected word leaves the mode untouched;
- `last_beat` only occurs inside a burst and is followed by silence unless a command restarts;
- the upper column bits stay fixed;
- a single-beat write ends at once;
- the read strobe trails read beats by the latency while that latency is steady.

The exact sequential and interleaved address orders, the burst lengths, and the cut-off of an interrupted burst are only shown by the bench's scenarios. So are the reset defaults and the silence of ignored command codes.

// File: rtl/sdram_colgen_pkg.sv
package sdram_colgen_pkg;

    localparam int LEN_LOG2_MAX = 3;
    localparam int LEN_LOG2_W   = 2;
    localparam int CAS_W        = 2;

    typedef enum logic [1:0] {
        CMD_MODE  = 2'b00,
        CMD_READ  = 2'b01,
        CMD_WRITE = 2'b10,
        CMD_NONE  = 2'b11
    } cmd_e;

    typedef enum logic {
        ORD_SEQ   = 1'b0,
        ORD_INTLV = 1'b1
    } order_e;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_BURST = 1'b1
    } bstate_e;

    typedef struct packed {
        logic [LEN_LOG2_W-1:0] len_log2;
        order_e                order;
        logic [CAS_W-1:0]      cas;
        logic                  single_wr;
    } mode_t;

    localparam mode_t MODE_RESET = '{len_log2: '0, order: ORD_SEQ,
                                     cas: CAS_W'(2), single_wr: 1'b0};

endpackage

// File: rtl/sdram_colgen_mode.sv
module sdram_colgen_mode
    import sdram_colgen_pkg::*;
#(
    parameter int WORD_W = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set_en,
    input  logic [WORD_W-1:0] word,
    output mode_t             mode_q,
    output logic              mode_error
);

    mode_t dec;
    logic  len_ok;
    logic  cas_ok;
    logic  rsv_clear;
    logic  word_ok;

    always_comb begin
        dec       = MODE_RESET;
        len_ok    = 1'b1;
        cas_ok    = 1'b1;
        unique case (word[2:0])
            3'b000:  dec.len_log2 = LEN_LOG2_W'(0);
            3'b001:  dec.len_log2 = LEN_LOG2_W'(1);
            3'b010:  dec.len_log2 = LEN_LOG2_W'(2);
            3'b011:  dec.len_log2 = LEN_LOG2_W'(3);
            default: len_ok = 1'b0;
        endcase
        unique case (word[6:4])
            3'b010:  dec.cas = CAS_W'(2);
            3'b011:  dec.cas = CAS_W'(3);
            default: cas_ok = 1'b0;
        endcase
        dec.order     = order_e'(word[3]);
        dec.single_wr = word[9];
        rsv_clear     = (word[WORD_W-1:10] == '0) && (word[8:7] == 2'b00);
        word_ok       = len_ok && cas_ok && rsv_clear;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q     <= MODE_RESET;
            mode_error <= 1'b0;
        end else if (set_en) begin
            mode_error <= !word_ok;
            if (word_ok) begin
                mode_q <= dec;
            end
        end
    end

    AST_REJECT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (set_en && !word_ok) |=> ($stable(mode_q) && mode_error)); // R2

    AST_ACCEPT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (set_en && word_ok) |=> !mode_error); // R2

endmodule

// File: rtl/sdram_colgen_burst.sv
module sdram_colgen_burst
    import sdram_colgen_pkg::*;
#(
    parameter int COL_W = 10
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic                  start_wr,
    input  logic [COL_W-1:0]      col_in,
    input  logic [LEN_LOG2_W-1:0] len_log2,
    input  order_e                order,
    input  logic                  single_wr,
    output logic [COL_W-1:0]      col_out,
    output logic                  beat_valid,
    output logic                  last_beat,
    output logic                  beat_rd
);

    localparam int CNT_W = LEN_LOG2_MAX;

    bstate_e               state_q, state_d;
    logic [CNT_W-1:0]      cnt_q, cnt_d;
    logic [COL_W-1:0]      base_q, base_d;
    logic [LEN_LOG2_W-1:0] lg_q, lg_d;
    order_e                ord_q, ord_d;
    logic                  rd_q, rd_d;

    logic [CNT_W-1:0]      last_idx;
    logic [COL_W-1:0]      mask;
    logic [COL_W-1:0]      low_seq;
    logic [COL_W-1:0]      low_int;
    logic                  at_last;

    assign last_idx = CNT_W'((1 << lg_q) - 1);
    assign mask     = COL_W'((1 << lg_q) - 1);
    assign at_last  = (cnt_q == last_idx);

    // next-state and burst bookkeeping
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        base_d  = base_q;
        lg_d    = lg_q;
        ord_d   = ord_q;
        rd_d    = rd_q;
        if (start) begin
            state_d = ST_BURST;               // START or RESTART
            cnt_d   = '0;
            base_d  = col_in;
            lg_d    = (start_wr && single_wr) ? '0 : len_log2;
            ord_d   = order;
            rd_d    = !start_wr;
        end else begin
            unique case (state_q)
                ST_IDLE: ;
                ST_BURST: begin
                    if (at_last) begin
                        state_d = ST_IDLE;    // FINISH
                    end else begin
                        cnt_d = cnt_q + CNT_W'(1); // ADVANCE
                    end
                end
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            base_q  <= '0;
            lg_q    <= '0;
            ord_q   <= ORD_SEQ;
            rd_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            base_q  <= base_d;
            lg_q    <= lg_d;
            ord_q   <= ord_d;
            rd_q    <= rd_d;
        end
    end

    // outputs
    always_comb begin
        low_seq    = base_q + COL_W'(cnt_q);
        low_int    = base_q ^ COL_W'(cnt_q);
        beat_valid = (state_q == ST_BURST);
        last_beat  = beat_valid && at_last;
        beat_rd    = beat_valid && rd_q;
        if (ord_q == ORD_INTLV) begin
            col_out = (base_q & ~mask) | (low_int & mask);
        end else begin
            col_out = (base_q & ~mask) | (low_seq & mask);
        end
    end

    AST_FIRST_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (beat_valid && col_out == $past(col_in))); // R4

    AST_LAST_IN_BURST: assert property (@(posedge clk) disable iff (!rst_n)
        last_beat |-> beat_valid); // R8

    AST_BURST_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (last_beat && !start) |=> !beat_valid); // R4

    AST_UPPER_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_valid && $past(beat_valid) && !$past(start))
            |-> (((col_out ^ $past(col_out)) & ~mask) == '0)); // R7

    AST_SINGLE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (start && start_wr && single_wr) |=> last_beat); // R9

endmodule

// File: rtl/sdram_colgen_rdlat.sv
module sdram_colgen_rdlat #(
    parameter int MAX_CL = 3,
    parameter int CL_W   = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            beat_rd,
    input  logic [CL_W-1:0] cas,
    output logic            rd_valid
);

    localparam int IDX_W = (MAX_CL > 1) ? $clog2(MAX_CL) : 1;

    logic [MAX_CL-1:0] pipe_q;
    logic [IDX_W-1:0]  tap;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pipe_q <= '0;
        end else begin
            pipe_q[0] <= beat_rd;
            for (int i = 1; i < MAX_CL; i++) begin
                pipe_q[i] <= pipe_q[i-1];
            end
        end
    end

    assign tap      = IDX_W'(cas - CL_W'(1));
    assign rd_valid = pipe_q[tap];

    AST_RD_LAT2: assert property (@(posedge clk) disable iff (!rst_n)
        (cas == CL_W'(2) && $past(cas) == CL_W'(2) && $past(cas, 2) == CL_W'(2))
            |-> (rd_valid == $past(beat_rd, 2))); // R11

    AST_RD_LAT3: assert property (@(posedge clk) disable iff (!rst_n)
        (cas == CL_W'(3) && $past(cas) == CL_W'(3) && $past(cas, 3) == CL_W'(3))
            |-> (rd_valid == $past(beat_rd, 3))); // R11

endmodule

// File: rtl/sdram_burst_colgen.sv
module sdram_burst_colgen
    import sdram_colgen_pkg::*;
#(
    parameter int ADDR_W = 14,
    parameter int COL_W  = 10,
    parameter int MAX_CL = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [1:0]        cmd_type,
    input  logic [ADDR_W-1:0] addr_in,
    output logic [COL_W-1:0]  col_addr_out,
    output logic              beat_valid,
    output logic              last_beat,
    output logic              rd_data_valid,
    output logic              mode_error
);

    cmd_e  cmd;
    mode_t mode;
    logic  set_en;
    logic  start;
    logic  start_wr;
    logic  beat_rd;

    assign cmd      = cmd_e'(cmd_type);
    assign set_en   = cmd_valid && (cmd == CMD_MODE);
    assign start    = cmd_valid && ((cmd == CMD_READ) || (cmd == CMD_WRITE));
    assign start_wr = (cmd == CMD_WRITE);

    sdram_colgen_mode #(.WORD_W(ADDR_W)) u_mode (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_en     (set_en),
        .word       (addr_in),
        .mode_q     (mode),
        .mode_error (mode_error)
    );

    sdram_colgen_burst #(.COL_W(COL_W)) u_burst (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .start_wr   (start_wr),
        .col_in     (addr_in[COL_W-1:0]),
        .len_log2   (mode.len_log2),
        .order      (mode.order),
        .single_wr  (mode.single_wr),
        .col_out    (col_addr_out),
        .beat_valid (beat_valid),
        .last_beat  (last_beat),
        .beat_rd    (beat_rd)
    );

    sdram_colgen_rdlat #(.MAX_CL(MAX_CL), .CL_W(CAS_W)) u_rdlat (
        .clk      (clk),
        .rst_n    (rst_n),
        .beat_rd  (beat_rd),
        .cas      (mode.cas),
        .rd_valid (rd_data_valid)
    );

    AST_NO_BEAT_AFTER_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (!start && !beat_valid) |=> !beat_valid); // R12

endmodule

// File: tb/sdram_burst_colgen_test.sv
module sdram_burst_colgen_test;

    localparam int CLK_PERIOD = 10;
    localparam int NV = 9;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_valid = 1'b0;
    logic [1:0] cmd_type = 2'b11;
    logic [13:0] addr_in = '0;
    logic [9:0] col_addr_out;
    logic       beat_valid, last_beat, rd_data_valid, mode_error;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sdram_burst_colgen uut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_type(cmd_type),
        .addr_in(addr_in), .col_addr_out(col_addr_out), .beat_valid(beat_valid),
        .last_beat(last_beat), .rd_data_valid(rd_data_valid), .mode_error(mode_error)
    );

    // mode word, write flag, column, beat count, expected columns
    localparam logic [13:0] T_MODE [NV] = '{14'h022, 14'h02A, 14'h033, 14'h03B,
                                            14'h021, 14'h020, 14'h222, 14'h222, 14'h023};
    localparam bit          T_WR   [NV] = '{0, 0, 0, 0, 0, 0, 1, 0, 1};
    localparam logic [9:0]  T_COL  [NV] = '{10'h005, 10'h00E, 10'h015, 10'h3FD,
                                            10'h101, 10'h2AA, 10'h007, 10'h007, 10'h00A};
    localparam int          T_N    [NV] = '{4, 4, 8, 8, 2, 1, 1, 4, 8};
    localparam logic [9:0]  T_EXP  [NV][8] = '{
        '{10'h005, 10'h006, 10'h007, 10'h004, 0, 0, 0, 0},
        '{10'h00E, 10'h00F, 10'h00C, 10'h00D, 0, 0, 0, 0},
        '{10'h015, 10'h016, 10'h017, 10'h010, 10'h011, 10'h012, 10'h013, 10'h014},
        '{10'h3FD, 10'h3FC, 10'h3FF, 10'h3FE, 10'h3F9, 10'h3F8, 10'h3FB, 10'h3FA},
        '{10'h101, 10'h100, 0, 0, 0, 0, 0, 0},
        '{10'h2AA, 0, 0, 0, 0, 0, 0, 0},
        '{10'h007, 0, 0, 0, 0, 0, 0, 0},
        '{10'h007, 10'h004, 10'h005, 10'h006, 0, 0, 0, 0},
        '{10'h00A, 10'h00B, 10'h00C, 10'h00D, 10'h00E, 10'h00F, 10'h008, 10'h009}
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // drive at a falling edge; returns at the next falling edge
    task automatic send(input logic [1:0] t, input logic [13:0] a);
        cmd_valid = 1'b1;
        cmd_type  = t;
        addr_in   = a;
        @(negedge clk);
        cmd_valid = 1'b0;
        cmd_type  = 2'b11;
        addr_in   = '0;
    endtask

    task automatic beat_chk(input string req, input logic [9:0] exp, input bit exp_last);
        chk(beat_valid && col_addr_out == exp && last_beat == exp_last, req,
            {beat_valid, last_beat, col_addr_out}, {1'b1, exp_last, exp});
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            finish_run();
        end
    end

    initial begin
        logic [15:0] pat;
        repeat (3) @(negedge clk);
        // R3: reset state
        chk(!beat_valid && !last_beat && !rd_data_valid && !mode_error, "R3",
            {beat_valid, last_beat, rd_data_valid, mode_error}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!beat_valid && !mode_error, "R3", {beat_valid, mode_error}, 0);

        // R3: default mode is length 1, latency 2
        pat = '0;
        send(2'b01, 14'h013);
        beat_chk("R3", 10'h013, 1'b1);
        for (int k = 0; k < 6; k++) begin
            pat[k] = rd_data_valid;
            if (k > 0) chk(!beat_valid, "R3", beat_valid, 0);
            @(negedge clk);
        end
        chk(pat[5:0] == 6'b000100, "R3 R11", pat[5:0], 6'b000100);

        // table of mode/command vectors: R1 R4 R5 R6 R8 R9
        for (int v = 0; v < NV; v++) begin
            send(2'b00, T_MODE[v]);
            chk(!mode_error, "R1", mode_error, 0);
            send(T_WR[v] ? 2'b10 : 2'b01, {4'h0, T_COL[v]});
            for (int i = 0; i <= T_N[v]; i++) begin
                if (i < T_N[v])
                    beat_chk("R4 R5 R6 R8 R9", T_EXP[v][i], i == T_N[v] - 1);
                else
                    chk(!beat_valid && !last_beat, "R4 R8", beat_valid, 0);
                @(negedge clk);
            end
            repeat (4) @(negedge clk);
        end

        // R2: rejected words keep the stored mode
        send(2'b00, 14'h022);
        chk(!mode_error, "R2", mode_error, 0);
        send(2'b00, 14'h1033);
        chk(mode_error, "R2", mode_error, 1);
        send(2'b00, 14'h024);
        chk(mode_error, "R2", mode_error, 1);
        send(2'b00, 14'h042);
        chk(mode_error, "R2", mode_error, 1);
        send(2'b00, 14'h0A3);
        chk(mode_error, "R2", mode_error, 1);
        send(2'b01, 14'h005);
        for (int i = 0; i < 4; i++) begin
            beat_chk("R2", T_EXP[0][i], i == 3);
            @(negedge clk);
        end
        chk(!beat_valid, "R2", beat_valid, 0);

        // R12: ignored commands
        send(2'b11, 14'h033);
        chk(mode_error && !beat_valid, "R12", {mode_error, beat_valid}, 2'b10);
        cmd_valid = 1'b0; cmd_type = 2'b01; addr_in = 14'h005;
        @(negedge clk);
        cmd_type = 2'b11; addr_in = '0;
        chk(!beat_valid, "R12", beat_valid, 0);
        send(2'b00, 14'h022);
        chk(!mode_error, "R2", mode_error, 0);
        send(2'b01, 14'h005);
        beat_chk("R12", 10'h005, 1'b0);
        repeat (8) @(negedge clk);

        // R10: interrupt a running burst
        send(2'b00, 14'h023);
        send(2'b01, 14'h000);
        beat_chk("R10", 10'h000, 1'b0);
        @(negedge clk);
        beat_chk("R10", 10'h001, 1'b0);
        @(negedge clk);
        beat_chk("R10", 10'h002, 1'b0);
        send(2'b01, 14'h024);
        for (int i = 0; i < 8; i++) begin
            beat_chk("R10", 10'h020 | ((4 + i) % 8), i == 7);
            @(negedge clk);
        end
        chk(!beat_valid, "R10", beat_valid, 0);
        repeat (4) @(negedge clk);

        // R11: latency 3, length 2 read
        send(2'b00, 14'h031);
        pat = '0;
        send(2'b01, 14'h040);
        for (int k = 0; k < 8; k++) begin
            pat[k] = rd_data_valid;
            @(negedge clk);
        end
        chk(pat[7:0] == 8'b0001_1000, "R11", pat[7:0], 8'b0001_1000);
        // R11: writes never raise read-valid
        pat = '0;
        send(2'b10, 14'h040);
        for (int k = 0; k < 8; k++) begin
            pat[k] = rd_data_valid;
            @(negedge clk);
        end
        chk(pat[7:0] == 8'h00, "R11", pat[7:0], 0);
        // R11: latency 2, length 2 read
        send(2'b00, 14'h021);
        pat = '0;
        send(2'b01, 14'h040);
        for (int k = 0; k < 8; k++) begin
            pat[k] = rd_data_valid;
            @(negedge clk);
        end
        chk(pat[7:0] == 8'b0000_1100, "R11", pat[7:0], 8'b0000_1100);

        done = 1'b1;
        finish_run();
    end

endmodule